// File: doc/BRIEF.md
# System configuration register bridge

This block is a small memory-mapped register window. Through it, software can ask for the frequency of a board clock source. Software loads a data word, then writes a command word to the control register. The command word names a destination: a controller id, a site, a position, a function and a device. When its start bit is set, the command is carried out in the cycle in which it is written.

A read command aimed at the oscillator function puts a fixed frequency into the data register. Software can fetch that value with its very next bus access. A write command is accepted and then discarded. The control register always reports "not busy" and the status register always reports "ready", so polling software never stalls.

A flags register is also provided. It can be set bit by bit and cleared as a whole. The bus port is a simple single-cycle register interface, and read data comes back one clock after the request.

Top module: `sys_cfg_bridge`

## Requirements
- R1: After a synchronous active-high reset, the data register, the flags register and the read data output are all 0.
- R2: A bus write to offset 0xA0 stores the write data in the data register, and a bus read of 0xA0 returns it.
- R3: A write to the control register at offset 0xA4 with bit 31 (start) clear leaves the data register unchanged.
- R4: A started read command (bit 31 = 1, bit 30 = 0) with controller id (bits 29:26) = 0, position (bits 15:12) = 0, function (bits 25:20) = 1 and site (bits 17:16) = 0 loads the data register according to the device field (bits 11:0): 25000000 for devices 0 and 1, 24000000 for device 2, and 0 for any other device.
- R5: The same command with site = 1 loads 50000000 for device 0, 40000000 for devices 4, 7 and 8, 50000000 for device 5, 35000000 for device 6, and 0 for any other device.
- R6: A started read command with a nonzero controller id, a nonzero position, a function other than 1, or a site of 2 or 3 leaves the data register unchanged.
- R7: A started write command (bit 30 = 1) leaves the data register and the flags register unchanged.
- R8: A read of the control register returns 0, and a read of the status register at offset 0xA8 returns 1.
- R9: A read from any unmapped offset returns 0. Unmapped offsets are everything outside the 0xD4-byte window, any offset that is not word-aligned, and any offset that is not assigned. Writes to unmapped offsets, and to the status register, change no state.
- R10: A write to offset 0x30 ORs the write data into the flags register. A write to offset 0x34 clears the flags register to 0. A read of either offset returns the flags.
- R11: Read data is registered. It appears one clock after the read request and holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench builds the bridge with its default 8-bit offset width. At that width every offset above the 0xD4 window can still be reached, so the out-of-window and misaligned cases can be tried directly. The small configuration makes full sweeps affordable:
- all four sites against the first sixteen devices, plus the largest device code;
- every function code;
- every controller id;
- every position.

In each sweep, a preloaded sentinel value shows whether a command wrongly changed the data register.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int unsigned DATA_W = 32;

    // Register offsets (bytes)
    localparam logic [7:0] OFF_FLAG_SET = 8'h30;
    localparam logic [7:0] OFF_FLAG_CLR = 8'h34;
    localparam logic [7:0] OFF_DATA     = 8'hA0;
    localparam logic [7:0] OFF_CTRL     = 8'hA4;
    localparam logic [7:0] OFF_STAT     = 8'hA8;
    localparam int unsigned WINDOW_BYTES = 'hD4;

    // Oscillator frequencies (Hz)
    localparam logic [DATA_W-1:0] HZ_25M = 32'd25_000_000;
    localparam logic [DATA_W-1:0] HZ_24M = 32'd24_000_000;
    localparam logic [DATA_W-1:0] HZ_50M = 32'd50_000_000;
    localparam logic [DATA_W-1:0] HZ_40M = 32'd40_000_000;
    localparam logic [DATA_W-1:0] HZ_35M = 32'd35_000_000;

    localparam logic [5:0] FUNC_OSC = 6'd1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FLAG_SET,
        SEL_FLAG_CLR,
        SEL_DATA,
        SEL_CTRL,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        logic        start;
        logic        is_write;
        logic [3:0]  ctrl_id;
        logic [5:0]  func;
        logic [1:0]  site;
        logic [3:0]  pos;
        logic [11:0] dev;
    } cfg_cmd_t;

    function automatic cfg_cmd_t unpack_cmd(input logic [DATA_W-1:0] w);
        cfg_cmd_t c;
        c.start    = w[31];
        c.is_write = w[30];
        c.ctrl_id  = w[29:26];
        c.func     = w[25:20];
        c.site     = w[17:16];
        c.pos      = w[15:12];
        c.dev      = w[11:0];
        return c;
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import sysreg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam int unsigned LAST_BYTE = WINDOW_BYTES - 1;

    logic in_window;
    logic aligned;

    assign in_window = (32'(addr) <= LAST_BYTE);
    assign aligned   = (addr[1:0] == 2'b00);

    always_comb begin
        sel = SEL_NONE;
        if (in_window && aligned) begin
            if      (addr == ADDR_W'(OFF_FLAG_SET)) sel = SEL_FLAG_SET;
            else if (addr == ADDR_W'(OFF_FLAG_CLR)) sel = SEL_FLAG_CLR;
            else if (addr == ADDR_W'(OFF_DATA))     sel = SEL_DATA;
            else if (addr == ADDR_W'(OFF_CTRL))     sel = SEL_CTRL;
            else if (addr == ADDR_W'(OFF_STAT))     sel = SEL_STAT;
        end
    end

endmodule

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
    import sysreg_pkg::*;
(
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_word,
    output cfg_cmd_t          cmd,
    output logic              osc_read_req
);

    logic dest_ok;

    assign cmd     = unpack_cmd(ctrl_word);
    assign dest_ok = (cmd.ctrl_id == 4'd0) && (cmd.pos == 4'd0) && (cmd.func == FUNC_OSC);

    // Only a started, non-write command to the oscillator function is serviced
    assign osc_read_req = ctrl_wr && cmd.start && !cmd.is_write && dest_ok;

endmodule

// File: rtl/cfg_osc_rom.sv
module cfg_osc_rom
    import sysreg_pkg::*;
(
    input  logic [1:0]        site,
    input  logic [11:0]       dev,
    output logic              hit,
    output logic [DATA_W-1:0] freq
);

    logic [DATA_W-1:0] mb_freq;
    logic [DATA_W-1:0] tile_freq;

    always_comb begin
        unique case (dev)
            12'd0, 12'd1: mb_freq = HZ_25M;
            12'd2:        mb_freq = HZ_24M;
            default:      mb_freq = '0;
        endcase
    end

    always_comb begin
        unique case (dev)
            12'd0, 12'd5:        tile_freq = HZ_50M;
            12'd4, 12'd7, 12'd8: tile_freq = HZ_40M;
            12'd6:               tile_freq = HZ_35M;
            default:             tile_freq = '0;
        endcase
    end

    // Sites 2 and 3 are not populated: no load
    assign hit  = (site == 2'd0) || (site == 2'd1);
    assign freq = (site == 2'd0) ? mb_freq : tile_freq;

endmodule

// File: rtl/sys_cfg_bridge.sv
module sys_cfg_bridge
    import sysreg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd_en,
    output logic [31:0]       bus_rdata
);

    reg_sel_e          sel;
    cfg_cmd_t          cmd;
    logic              osc_read_req;
    logic              rom_hit;
    logic [DATA_W-1:0] rom_freq;
    logic              load_freq;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] flags_q;
    logic [DATA_W-1:0] rd_mux;

    cfg_addr_decode #(.ADDR_W(ADDR_W)) addr_dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    cfg_cmd_decode cmd_dec_i (
        .ctrl_wr      (bus_wr_en && (sel == SEL_CTRL)),
        .ctrl_word    (bus_wdata),
        .cmd          (cmd),
        .osc_read_req (osc_read_req)
    );

    cfg_osc_rom osc_rom_i (
        .site (cmd.site),
        .dev  (cmd.dev),
        .hit  (rom_hit),
        .freq (rom_freq)
    );

    assign load_freq = osc_read_req && rom_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (bus_wr_en && sel == SEL_DATA) begin
            data_q <= bus_wdata;
        end else if (load_freq) begin
            data_q <= rom_freq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (bus_wr_en && sel == SEL_FLAG_SET) begin
            flags_q <= flags_q | bus_wdata;
        end else if (bus_wr_en && sel == SEL_FLAG_CLR) begin
            flags_q <= '0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_FLAG_SET, SEL_FLAG_CLR: rd_mux = flags_q;
            SEL_DATA:                   rd_mux = data_q;
            SEL_STAT:                   rd_mux = 32'd1;
            default:                    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd_en) begin
            bus_rdata <= rd_mux;
        end
    end

    // R2
    data_store_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && sel == SEL_DATA) |=> (data_q == $past(bus_wdata)));

    // R3
    idle_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && sel == SEL_CTRL && !bus_wdata[31]) |=> $stable(data_q));

    // R7
    wr_cmd_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && sel == SEL_CTRL && bus_wdata[31] && bus_wdata[30])
        |=> ($stable(data_q) && $stable(flags_q)));

    // R8
    status_one_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && sel == SEL_STAT) |=> (bus_rdata == 32'd1));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && sel == SEL_NONE) |=> (bus_rdata == 32'd0));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |=> $stable(bus_rdata));

endmodule

// File: tb/sys_cfg_bridge_tb_top.sv
module sys_cfg_bridge_tb_top;

    localparam int unsigned ADDR_W = 8;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr_en = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd_en = 1'b0;
    logic [31:0]       bus_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sys_cfg_bridge #(.ADDR_W(ADDR_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rd_en (bus_rd_en),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input logic wrb, input int cid, input int fn,
                                             input int site, input int pos, input int dev);
        return {1'b1, wrb, 4'(cid), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
    endfunction

    // Expected frequency per requirement tables R4 and R5
    function automatic logic [31:0] exp_freq(input int site, input int dev, input logic [31:0] prev);
        if (site == 0) begin
            if (dev == 0 || dev == 1) return 32'd25000000;
            if (dev == 2) return 32'd24000000;
            return 32'd0;
        end else if (site == 1) begin
            if (dev == 0 || dev == 5) return 32'd50000000;
            if (dev == 4 || dev == 7 || dev == 8) return 32'd40000000;
            if (dev == 6) return 32'd35000000;
            return 32'd0;
        end
        return prev;
    endfunction

    task automatic probe(input string req, input logic [31:0] cw, input logic [31:0] exp);
        logic [31:0] v;
        wr(8'hA0, SENT);
        wr(8'hA4, cw);
        rd(8'hA0, v);
        check(req, v, exp);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", checks);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        check("R1 rdata", bus_rdata, 32'd0);
        rd(8'hA0, v); check("R1 data", v, 32'd0);
        rd(8'h30, v); check("R1 flags", v, 32'd0);

        // R2
        wr(8'hA0, 32'h1234_5678);
        rd(8'hA0, v); check("R2", v, 32'h1234_5678);

        // R11 hold after idle cycles
        repeat (3) @(negedge clk);
        check("R11 hold", bus_rdata, 32'h1234_5678);

        // R3: start clear, otherwise a valid oscillator read
        probe("R3", cmd_word(1'b0, 0, 1, 0, 0, 0) & 32'h7FFF_FFFF, SENT);

        // R4 / R5 / R6 site sweep
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 16; d++)
                probe(s == 0 ? "R4" : (s == 1 ? "R5" : "R6 site"),
                      cmd_word(1'b0, 0, 1, s, 0, d), exp_freq(s, d, SENT));
            probe(s == 0 ? "R4 maxdev" : (s == 1 ? "R5 maxdev" : "R6 maxdev"),
                  cmd_word(1'b0, 0, 1, s, 0, 4095), exp_freq(s, 4095, SENT));
        end

        // R6 function, controller id and position sweeps
        for (int f = 0; f < 64; f++)
            probe("R6 func", cmd_word(1'b0, 0, f, 0, 0, 2), f == 1 ? 32'd24000000 : SENT);
        for (int c = 1; c < 16; c++)
            probe("R6 cid", cmd_word(1'b0, c, 1, 1, 0, 6), SENT);
        for (int p = 1; p < 16; p++)
            probe("R6 pos", cmd_word(1'b0, 0, 1, 1, p, 6), SENT);

        // R7
        wr(8'h30, 32'h0000_00A5);
        probe("R7 data", cmd_word(1'b1, 0, 1, 0, 0, 0), SENT);
        rd(8'h30, v); check("R7 flags", v, 32'h0000_00A5);

        // R8
        rd(8'hA4, v); check("R8 ctrl", v, 32'd0);
        rd(8'hA8, v); check("R8 stat", v, 32'd1);

        // R9 unmapped reads and ignored writes
        rd(8'h00, v); check("R9 rd 00", v, 32'd0);
        rd(8'hD4, v); check("R9 rd D4", v, 32'd0);
        rd(8'hFC, v); check("R9 rd FC", v, 32'd0);
        rd(8'hA1, v); check("R9 rd A1", v, 32'd0);
        wr(8'hA0, SENT);
        wr(8'hA8, 32'h5555_5555);
        wr(8'hA2, 32'h5555_5555);
        wr(8'hD4, 32'h5555_5555);
        wr(8'h31, 32'hFFFF_FFFF);
        rd(8'hA0, v); check("R9 data kept", v, SENT);
        rd(8'hA8, v); check("R9 stat kept", v, 32'd1);
        rd(8'h30, v); check("R9 flags kept", v, 32'h0000_00A5);

        // R10
        wr(8'h30, 32'h0000_0F00);
        rd(8'h30, v); check("R10 set", v, 32'h0000_0FA5);
        rd(8'h34, v); check("R10 rd clr", v, 32'h0000_0FA5);
        wr(8'h34, 32'h0000_0001);
        rd(8'h30, v); check("R10 clr", v, 32'd0);

        // R11 one-cycle latency of a fresh result
        wr(8'hA4, cmd_word(1'b0, 0, 1, 1, 0, 8));
        rd(8'hA0, v); check("R11 next access", v, 32'd40000000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule